// File: doc/BRIEF.md
# Speculative Resilient Stage Handshake Controller

This block is a cycle-level, clocked model of the controller for one stage of a timing-resilient bundled-data pipeline. A token arrives on a four-phase request/acknowledge pair from the upstream stage. The block first asks the upstream stage, over an error-check request/acknowledge pair, whether the data it sent has settled. It then waits a programmable nominal delay δ and issues its downstream request speculatively, before the data is guaranteed stable. One cycle later it opens the latch enable and a sample strobe for a programmable window Δ. During this window late transitions on the datapath are watched.

When the window closes, the block reads a dual-rail error result. Bit 0 high alone means the data was on time, and the token completes at once. Bit 1 high alone means a late arrival, and completion is held back by a further Δ cycles. The downstream stage can poll the outcome on its own error-check pair, and it gets an answer only once the result is resolved. Internally a left part (upstream side), a right part (downstream side) and a bottom part (latch and strobe) coordinate through go and error-delay signals. One shared counter measures both δ and Δ. Both delays are captured from configuration inputs while reset is held.

Top module: `resilientStageCtl`

## Requirements
- R1: While reset is low the block captures cfgNominal as δ and cfgWindow as Δ. paramErr is high exactly when Δ > δ, δ = 0 or Δ = 0. While paramErr is high, a raised inReq is ignored: leReq and inAck stay low.
- R2: On the first cycle after reset, inAck, leReq, outReq, reChkAck, latchEn, sampleEn and railFault are all low.
- R3: When the stage is idle, inAck is low and the previous token has fully finished, a high inReq raises leReq at the next clock edge. While inAck is high, an inReq that is still held high starts no new token.
- R4: outReq rises δ+1 clock edges after the edge that samples leAck high, before any error result is known.
- R5: latchEn and sampleEn rise together one edge after outReq rises and stay high for exactly Δ cycles.
- R6: If errRails is 2'b01 (bit 0 = on time) on the first edge after the window closes, inAck rises two edges after the window closes, and leReq falls on that same edge.
- R7: If errRails is 2'b10 (bit 1 = late arrival) on that edge, inAck rises Δ edges later than in R6.
- R8: errRails = 2'b11 sets railFault, which then stays high until reset. With errRails at 2'b11 or 2'b00 the token stays unresolved and inAck stays low until exactly one rail is high.
- R9: reChkAck rises only while reChkReq is high, after the outReq/outAck pair has returned low and after the error result has been resolved. It never rises before inAck does, and it falls once reChkReq is low.
- R10: outReq falls on the edge after outAck is sampled high. inAck falls only once inReq and leAck are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock; δ and Δ are counted in its cycles |
| rstN | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfgNominal | input | W | Nominal delay δ in cycles |
| cfgWindow | input | W | Resiliency window Δ in cycles |
| inReq | input | 1 | Upstream request (four-phase) |
| inAck | output | 1 | Upstream acknowledge |
| leReq | output | 1 | Error-check request toward the upstream stage |
| leAck | input | 1 | Upstream reply: its data is settled |
| outReq | output | 1 | Speculative downstream request |
| outAck | input | 1 | Downstream acknowledge |
| reChkReq | input | 1 | Downstream error-check request |
| reChkAck | output | 1 | Error-check acknowledge to the downstream stage |
| errRails | input | 2 | Dual-rail error result: bit 0 on time, bit 1 late |
| latchEn | output | 1 | Latch enable, high for the window |
| sampleEn | output | 1 | Error-window sample strobe |
| paramErr | output | 1 | Captured configuration is illegal |
| railFault | output | 1 | Sticky flag: both error rails were seen high |

## Verification
The bench builds the block with W = 4, so δ and Δ can reach their full range of 15 and the shared counter runs up to its top code. Each run under reset loads a new pair: 4/2 for the ordinary case, 3/3 for the Δ = δ boundary, 1/1 for the shortest timing and 15/15 for the widest windows. The illegal pairs are 2/5, 0/0 and 3/0. Under these settings the bench exercises on-time tokens, late tokens, rails held at 2'b00 and at 2'b11, and an inReq held high after it is acknowledged.

// File: rtl/stagePkg.sv
package stagePkg;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } tmrCmd_t;

  typedef struct packed {
    logic hitNom;
    logic hitWin;
    logic cfgBad;
  } tmrStat_t;

  typedef enum logic [1:0] {
    L_IDLE, L_CHECK, L_RUN, L_DONE
  } leftSt_t;

  typedef enum logic [2:0] {
    R_IDLE, R_NOM, R_REQ, R_REL, R_CHK, R_FIN, R_DONE
  } rightSt_t;

  typedef enum logic [2:0] {
    B_IDLE, B_WIN, B_RES, B_PEN, B_HOLD
  } botSt_t;

  localparam logic [1:0] RAIL_OK   = 2'b01;
  localparam logic [1:0] RAIL_LATE = 2'b10;
  localparam logic [1:0] RAIL_BOTH = 2'b11;

endpackage

// File: rtl/stageTiming.sv
module stageTiming
  import stagePkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cfgNominal,
  input  logic [W-1:0] cfgWindow,
  input  tmrCmd_t      cmd,
  output tmrStat_t     stat
);

  localparam logic [W-1:0] CNT_FIRST = W'(1);
  localparam logic [W-1:0] CNT_ZERO  = '0;

  logic [W-1:0] nomQ;
  logic [W-1:0] winQ;
  logic [W-1:0] cnt;
  logic         badQ;

  // configuration is captured every cycle while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nomQ <= cfgNominal;
      winQ <= cfgWindow;
      badQ <= (cfgWindow > cfgNominal) || (cfgNominal == CNT_ZERO) ||
              (cfgWindow == CNT_ZERO);
      cnt  <= CNT_ZERO;
    end else if (cmd.cntClear) begin
      cnt <= CNT_FIRST;
    end else if (cmd.cntStep) begin
      cnt <= cnt + CNT_FIRST;
    end
  end

  assign stat.hitNom = (cnt == nomQ);
  assign stat.hitWin = (cnt == winQ);
  assign stat.cfgBad = badQ;

endmodule

// File: rtl/stageSequencer.sv
module stageSequencer
  import stagePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inReq,
  input  logic       leAck,
  input  logic       outAck,
  input  logic       reChkReq,
  input  logic [1:0] errRails,
  input  tmrStat_t   stat,
  output tmrCmd_t    cmd,
  output logic       inAck,
  output logic       leReq,
  output logic       outReq,
  output logic       reChkAck,
  output logic       latchEn,
  output logic       sampleEn,
  output logic       railFault
);

  leftSt_t  lSt;
  rightSt_t rSt;
  botSt_t   bSt;

  logic goL, goR, goD, goDq;
  logic edo, edi;

  logic goDRise;
  logic rightClear, rightStep, botClear, botStep;

  assign goDRise    = goD && !goDq;
  assign rightClear = (rSt == R_IDLE) && goR;
  assign rightStep  = (rSt == R_NOM) && !stat.hitNom;
  assign botClear   = ((bSt == B_IDLE) && goDRise) ||
                      ((bSt == B_RES) && (errRails == RAIL_LATE));
  assign botStep    = ((bSt == B_WIN) || (bSt == B_PEN)) && !stat.hitWin;

  // the right and bottom parts never count at the same time
  assign cmd.cntClear = rightClear || botClear;
  assign cmd.cntStep  = rightStep || botStep;

  // left part: upstream request and upstream error check
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lSt   <= L_IDLE;
      leReq <= 1'b0;
      inAck <= 1'b0;
      goR   <= 1'b0;
    end else begin
      case (lSt)
        L_IDLE:
          if (inReq && !goL && !stat.cfgBad) begin
            leReq <= 1'b1;
            lSt   <= L_CHECK;
          end
        L_CHECK:
          if (leAck) begin
            goR <= 1'b1;
            lSt <= L_RUN;
          end
        L_RUN:
          if (goL) begin
            inAck <= 1'b1;
            leReq <= 1'b0;
            goR   <= 1'b0;
            lSt   <= L_DONE;
          end
        L_DONE:
          if (!inReq && !leAck) begin
            inAck <= 1'b0;
            lSt   <= L_IDLE;
          end
        default: lSt <= L_IDLE;
      endcase
    end
  end

  // right part: speculative downstream request and downstream error check
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rSt      <= R_IDLE;
      outReq   <= 1'b0;
      reChkAck <= 1'b0;
      goD      <= 1'b0;
      edi      <= 1'b0;
    end else begin
      case (rSt)
        R_IDLE:
          if (goR) rSt <= R_NOM;
        R_NOM:
          if (stat.hitNom) begin
            outReq <= 1'b1;
            goD    <= 1'b1;
            rSt    <= R_REQ;
          end
        R_REQ:
          if (outAck) begin
            outReq <= 1'b0;
            rSt    <= R_REL;
          end
        R_REL:
          if (!outAck) rSt <= R_CHK;
        R_CHK:
          if (reChkReq && edo) begin
            reChkAck <= 1'b1;
            rSt      <= R_FIN;
          end
        R_FIN:
          if (!reChkReq) begin
            reChkAck <= 1'b0;
            edi      <= 1'b1;
            rSt      <= R_DONE;
          end
        R_DONE:
          if (!edo) begin
            edi <= 1'b0;
            goD <= 1'b0;
            rSt <= R_IDLE;
          end
        default: rSt <= R_IDLE;
      endcase
    end
  end

  // bottom part: latch enable, sample window, error resolution and penalty
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSt       <= B_IDLE;
      goDq      <= 1'b0;
      latchEn   <= 1'b0;
      sampleEn  <= 1'b0;
      goL       <= 1'b0;
      edo       <= 1'b0;
      railFault <= 1'b0;
    end else begin
      goDq <= goD;
      case (bSt)
        B_IDLE:
          if (goDRise) begin
            latchEn  <= 1'b1;
            sampleEn <= 1'b1;
            bSt      <= B_WIN;
          end
        B_WIN:
          if (stat.hitWin) begin
            latchEn  <= 1'b0;
            sampleEn <= 1'b0;
            bSt      <= B_RES;
          end
        B_RES:
          if (errRails == RAIL_BOTH) begin
            railFault <= 1'b1;
          end else if (errRails == RAIL_OK) begin
            edo <= 1'b1;
            goL <= 1'b1;
            bSt <= B_HOLD;
          end else if (errRails == RAIL_LATE) begin
            bSt <= B_PEN;
          end
        B_PEN:
          if (stat.hitWin) begin
            edo <= 1'b1;
            goL <= 1'b1;
            bSt <= B_HOLD;
          end
        B_HOLD:
          if (edi) begin
            edo <= 1'b0;
            goL <= 1'b0;
            bSt <= B_IDLE;
          end
        default: bSt <= B_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/resilientStageCtl.sv
module resilientStageCtl
  import stagePkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cfgNominal,
  input  logic [W-1:0] cfgWindow,
  input  logic         inReq,
  output logic         inAck,
  output logic         leReq,
  input  logic         leAck,
  output logic         outReq,
  input  logic         outAck,
  input  logic         reChkReq,
  output logic         reChkAck,
  input  logic [1:0]   errRails,
  output logic         latchEn,
  output logic         sampleEn,
  output logic         paramErr,
  output logic         railFault
);

  tmrCmd_t  tmrCmd;
  tmrStat_t tmrStat;

  stageTiming #(.W(W)) uTiming (
    .clk        (clk),
    .rstN       (rstN),
    .cfgNominal (cfgNominal),
    .cfgWindow  (cfgWindow),
    .cmd        (tmrCmd),
    .stat       (tmrStat)
  );

  stageSequencer uSeq (
    .clk       (clk),
    .rstN      (rstN),
    .inReq     (inReq),
    .leAck     (leAck),
    .outAck    (outAck),
    .reChkReq  (reChkReq),
    .errRails  (errRails),
    .stat      (tmrStat),
    .cmd       (tmrCmd),
    .inAck     (inAck),
    .leReq     (leReq),
    .outReq    (outReq),
    .reChkAck  (reChkAck),
    .latchEn   (latchEn),
    .sampleEn  (sampleEn),
    .railFault (railFault)
  );

  assign paramErr = tmrStat.cfgBad;

endmodule

// File: rtl/resilientStageChk.sv
module resilientStageChk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] cfgWindow,
  input logic         inReq,
  input logic         inAck,
  input logic         leReq,
  input logic         leAck,
  input logic         outReq,
  input logic         outAck,
  input logic         reChkReq,
  input logic         reChkAck,
  input logic         latchEn,
  input logic         paramErr,
  input logic         railFault
);

  logic [W-1:0] winSnap;
  logic [W:0]   latchRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winSnap  <= cfgWindow;
      latchRun <= '0;
    end else if (latchEn) begin
      latchRun <= latchRun + 1'b1;
    end else begin
      latchRun <= '0;
    end
  end

  assert_bad_cfg_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    paramErr |-> (!leReq && !inAck));

  assert_check_needs_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(leReq) |-> $past(inReq));

  assert_spec_req_in_token_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReq) |-> (leReq && !inAck));

  assert_latch_after_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchEn) |-> $past(outReq));

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> (latchRun < {1'b0, winSnap}));

  assert_ack_drops_check_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inAck) |-> $fell(leReq));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    railFault |=> railFault);

  assert_chk_ack_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reChkAck) |-> ($past(reChkReq) && !outReq && !$past(outAck)));

  assert_out_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReq) |-> $past(outAck));

  assert_in_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inAck) |-> (!$past(inReq) && !$past(leAck)));

endmodule

bind resilientStageCtl resilientStageChk #(.W(W)) uChk (.*);

// File: tb/sim_resilientStageCtl.sv
module sim_resilientStageCtl;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] cfgNominal = '0;
  logic [W-1:0] cfgWindow = '0;
  logic         inReq = 1'b0;
  logic         leAck = 1'b0;
  logic         outAck = 1'b0;
  logic         reChkReq = 1'b0;
  logic [1:0]   errRails = 2'b00;
  logic         inAck, leReq, outReq, reChkAck, latchEn, sampleEn, paramErr, railFault;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int curNom = 0;
  int curWin = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  resilientStageCtl #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .cfgNominal(cfgNominal), .cfgWindow(cfgWindow),
    .inReq(inReq), .inAck(inAck), .leReq(leReq), .leAck(leAck),
    .outReq(outReq), .outAck(outAck), .reChkReq(reChkReq), .reChkAck(reChkAck),
    .errRails(errRails), .latchEn(latchEn), .sampleEn(sampleEn),
    .paramErr(paramErr), .railFault(railFault)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference, one step per clock ----------------
  int   phL = 0, phR = 0, phB = 0, cntR = 0, cntB = 0, mNom = 0, mWin = 0;
  bit   mBad = 0, sGoL = 0, sGoR = 0, sGoD = 0, sGoDOld = 0, sRes = 0, sRel = 0;
  bit   eInAck = 0, eLeReq = 0, eOutReq = 0, eReAck = 0, eLatch = 0, eRail = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mNom = int'(cfgNominal);
      mWin = int'(cfgWindow);
      mBad = (mWin > mNom) || (mNom == 0) || (mWin == 0);
      phL = 0; phR = 0; phB = 0; cntR = 0; cntB = 0;
      sGoL = 0; sGoR = 0; sGoD = 0; sGoDOld = 0; sRes = 0; sRel = 0;
      eInAck = 0; eLeReq = 0; eOutReq = 0; eReAck = 0; eLatch = 0; eRail = 0;
    end else begin
      bit oGoL, oGoR, oGoD, oGoDOld, oRes, oRel;
      oGoL = sGoL; oGoR = sGoR; oGoD = sGoD; oGoDOld = sGoDOld; oRes = sRes; oRel = sRel;
      sGoDOld = oGoD;
      // upstream side
      if (phL == 0 && inReq && !oGoL && !mBad) begin eLeReq = 1; phL = 1; end
      else if (phL == 1 && leAck) begin sGoR = 1; phL = 2; end
      else if (phL == 2 && oGoL) begin eInAck = 1; eLeReq = 0; sGoR = 0; phL = 3; end
      else if (phL == 3 && !inReq && !leAck) begin eInAck = 0; phL = 0; end
      // downstream side
      if (phR == 0) begin
        if (oGoR) begin cntR = 1; phR = 1; end
      end else if (phR == 1) begin
        if (cntR == mNom) begin eOutReq = 1; sGoD = 1; phR = 2; end else cntR++;
      end else if (phR == 2) begin
        if (outAck) begin eOutReq = 0; phR = 3; end
      end else if (phR == 3) begin
        if (!outAck) phR = 4;
      end else if (phR == 4) begin
        if (reChkReq && oRes) begin eReAck = 1; phR = 5; end
      end else if (phR == 5) begin
        if (!reChkReq) begin eReAck = 0; sRel = 1; phR = 6; end
      end else begin
        if (!oRes) begin sRel = 0; sGoD = 0; phR = 0; end
      end
      // latch window and resolution
      if (phB == 0) begin
        if (oGoD && !oGoDOld) begin eLatch = 1; cntB = 1; phB = 1; end
      end else if (phB == 1) begin
        if (cntB == mWin) begin eLatch = 0; phB = 2; end else cntB++;
      end else if (phB == 2) begin
        if (errRails == 2'b11) eRail = 1;
        else if (errRails == 2'b01) begin sRes = 1; sGoL = 1; phB = 4; end
        else if (errRails == 2'b10) begin cntB = 1; phB = 3; end
      end else if (phB == 3) begin
        if (cntB == mWin) begin sRes = 1; sGoL = 1; phB = 4; end else cntB++;
      end else begin
        if (oRel) begin sRes = 0; sGoL = 0; phB = 0; end
      end
    end
  end

  // ---------------- per-cycle comparison and event monitor ----------------
  int outRiseCyc, latchRiseCyc, latchFallCyc, latchCnt, inAckRiseCyc, reAckRiseCyc;
  bit pOut = 0, pLatch = 0, pInAck = 0, pReAck = 0;

  always @(negedge clk) begin
    if (rstN) begin
      check(leReq == eLeReq, "R3 leReq", leReq, eLeReq);
      check(outReq == eOutReq, "R4 outReq", outReq, eOutReq);
      check(latchEn == eLatch, "R5 latchEn", latchEn, eLatch);
      check(sampleEn == eLatch, "R5 sampleEn", sampleEn, eLatch);
      check(inAck == eInAck, "R6 inAck", inAck, eInAck);
      check(railFault == eRail, "R8 railFault", railFault, eRail);
      check(reChkAck == eReAck, "R9 reChkAck", reChkAck, eReAck);
      check(paramErr == mBad, "R1 paramErr", paramErr, mBad);
      if (outReq && !pOut) outRiseCyc = cyc;
      if (latchEn && !pLatch) latchRiseCyc = cyc;
      if (!latchEn && pLatch) latchFallCyc = cyc;
      if (latchEn) latchCnt++;
      if (inAck && !pInAck) inAckRiseCyc = cyc;
      if (reChkAck && !pReAck) reAckRiseCyc = cyc;
    end
    pOut = outReq; pLatch = latchEn; pInAck = inAck; pReAck = reChkAck;
  end

  task automatic resetWith(input int nom, input int win);
    bit expBad;
    @(negedge clk);
    rstN = 1'b0; inReq = 0; leAck = 0; outAck = 0; reChkReq = 0; errRails = 2'b00;
    cfgNominal = W'(nom); cfgWindow = W'(win);
    curNom = nom; curWin = win;
    repeat (3) @(negedge clk);
    // R2: quiet outputs after reset
    check({inAck, leReq, outReq, reChkAck, latchEn, sampleEn, railFault} == 7'b0,
          "R2 reset state", int'({inAck, leReq, outReq, reChkAck, latchEn, sampleEn, railFault}), 0);
    expBad = (win > nom) || (nom == 0) || (win == 0);
    check(paramErr == expBad, "R1 paramErr capture", paramErr, expBad);
    rstN = 1'b1;
  endtask

  task automatic runToken(input logic [1:0] firstR, input int hold, input logic [1:0] finalR,
                          input int gap, input bit keepReq);
    int ackCyc;
    latchCnt = 0;
    inReq = 1'b1;
    do @(negedge clk); while (!leReq);
    repeat (gap) @(negedge clk);
    leAck = 1'b1;
    ackCyc = cyc;
    do @(negedge clk); while (!outReq);
    check(cyc - ackCyc == curNom + 2, "R4 speculative request delay", cyc - ackCyc, curNom + 2);
    outAck = 1'b1;
    errRails = (hold > 0) ? firstR : finalR;
    @(negedge clk);
    check(outReq == 1'b0, "R10 outReq release", outReq, 0);
    while (outReq) @(negedge clk);
    outAck = 1'b0;
    reChkReq = 1'b1;
    if (hold > 0) begin
      while (latchEn) @(negedge clk);
      repeat (hold) @(negedge clk);
      check(inAck == 1'b0, "R8 unresolved rails hold token", inAck, 0);
      if (firstR == 2'b11) check(railFault == 1'b1, "R8 both rails flagged", railFault, 1);
      errRails = finalR;
    end
    while (!reChkAck) @(negedge clk);
    reChkReq = 1'b0;
    while (!inAck) @(negedge clk);
    if (keepReq) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(leReq == 1'b0, "R3 held inReq starts nothing", leReq, 0);
        check(inAck == 1'b1, "R10 inAck held while inReq high", inAck, 1);
      end
    end
    inReq = 1'b0; leAck = 1'b0; errRails = 2'b00;
    do @(negedge clk); while (inAck);
    if (hold == 0) begin
      check(latchCnt == curWin, "R5 window length", latchCnt, curWin);
      check(latchRiseCyc - outRiseCyc == 1, "R5 latch after request", latchRiseCyc - outRiseCyc, 1);
      if (finalR == 2'b01)
        check(inAckRiseCyc - latchFallCyc == 2, "R6 on-time completion", inAckRiseCyc - latchFallCyc, 2);
      else
        check(inAckRiseCyc - latchFallCyc == curWin + 2, "R7 late penalty",
              inAckRiseCyc - latchFallCyc, curWin + 2);
    end
    check(reAckRiseCyc >= inAckRiseCyc, "R9 check ack after resolution", reAckRiseCyc, inAckRiseCyc);
    repeat (2) @(negedge clk);
  endtask

  task automatic badConfig(input int nom, input int win);
    resetWith(nom, win);
    inReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!leReq && !inAck, "R1 request ignored on bad config", int'({leReq, inAck}), 0);
    end
    inReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    resetWith(4, 2);
    runToken(2'b01, 0, 2'b01, 1, 1'b0);
    runToken(2'b10, 0, 2'b10, 3, 1'b1);
    runToken(2'b11, 4, 2'b01, 0, 1'b0);
    runToken(2'b01, 0, 2'b01, 2, 1'b0);   // railFault stays set (R8)
    check(railFault == 1'b1, "R8 fault sticky", railFault, 1);

    resetWith(3, 3);
    runToken(2'b10, 0, 2'b10, 0, 1'b0);
    runToken(2'b00, 3, 2'b10, 1, 1'b1);

    resetWith(1, 1);
    runToken(2'b01, 0, 2'b01, 0, 1'b0);
    runToken(2'b10, 0, 2'b10, 0, 1'b0);

    resetWith(15, 15);
    runToken(2'b10, 0, 2'b10, 2, 1'b0);
    runToken(2'b01, 0, 2'b01, 0, 1'b1);

    badConfig(2, 5);
    badConfig(0, 0);
    badConfig(3, 0);

    resetWith(5, 2);
    check(paramErr == 1'b0, "R1 legal config", paramErr, 0);
    runToken(2'b01, 0, 2'b01, 1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule